// File: doc/BRIEF.md
# Segment Translation Unit

This unit keeps six segment slots, one for code, one for stack and four for data. Every slot pairs a selector with a hidden descriptor copy holding a 32-bit base, a 32-bit limit, a 4-bit attribute/type field and a usable flag. An address-generation request names a slot and a 32-bit offset. One cycle later the unit returns the linear address (the slot's base plus the offset) and a status. The status reports a limit violation, a null slot or a slot that is still loading.

Software never writes descriptor copies directly. A selector load names a slot and a 16-bit selector. The unit then asks an external descriptor-table port for the entry, choosing the global or the local table by one selector bit. It holds the request until the answer arrives. A present answer refills the slot. An answer marked not present raises a fault and leaves the slot exactly as it was. Only one load is in flight at a time. Address generation to other slots goes on while a load is waiting.

Top module: `seg_xlate`

## Requirements
- R1: After reset every slot is null. No table request is raised. An address request to any slot returns status NULL (2'd2).
- R2: An address request sampled on one rising edge produces `ag_done` high for exactly the following cycle. When the status is OK (2'd0), `ag_lin` equals base + offset modulo 2^32 and `ag_attr` is the slot's attribute field.
- R3: An offset strictly greater than the slot's limit gives status LIMIT (2'd1). An offset equal to the limit is OK.
- R4: The selector layout is: bits [15:3] are the table index, bit 2 chooses the table (0 global, 1 local), and bits [1:0] are ignored. A table request carries exactly that index and table bit.
- R5: A selector with global index 0 is null. Loading it raises no table request. `ld_done` is high the next cycle with no fault, and later address requests to that slot return NULL. A local index 0 is an ordinary table request.
- R6: `tbl_req` rises the cycle after a non-null load is accepted. It stays high with a stable index and table bit until a cycle in which `tbl_rsp_valid` is sampled, and is low after it.
- R7: A response with present = 1 refills the slot. `ld_done` is high the next cycle with `ld_np_fault` low. Address requests from that next cycle on use the new base, limit and attribute.
- R8: A response with present = 0 gives `ld_done` and `ld_np_fault` high together the next cycle. The slot keeps its previous descriptor, usable state included.
- R9: While a load is waiting, including the edge that samples the response, an address request to the loading slot returns BUSY (2'd3). Requests to other slots are served normally.
- R10: Some inputs are ignored and have no effect: a load while another load is waiting, a load naming slot code 6 or 7, and a table response while no load is waiting.
- R11: Status priority is BUSY, then NULL, then LIMIT. Slot codes 6 and 7 return NULL. `ag_lin` and `ag_attr` are zero whenever the status is not OK.
- R12: An address request sampled on the same edge that accepts a load to its slot uses the old descriptor and is not BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Selector load strobe |
| ld_seg | input | 3 | Slot to load (0 code, 1 stack, 2-5 data) |
| ld_sel | input | 16 | Selector value |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_np_fault | output | 1 | Finished load hit a not-present descriptor |
| tbl_req | output | 1 | Descriptor table request, held until answered |
| tbl_req_local | output | 1 | 1 = local table, 0 = global table |
| tbl_req_index | output | 13 | Table entry index |
| tbl_rsp_valid | input | 1 | Descriptor answer strobe |
| tbl_rsp_base | input | 32 | Answered base |
| tbl_rsp_limit | input | 32 | Answered limit (inclusive, bytes) |
| tbl_rsp_attr | input | 4 | Answered attribute/type field |
| tbl_rsp_present | input | 1 | Answered present flag |
| ag_valid | input | 1 | Address request strobe |
| ag_seg | input | 3 | Slot for the address request |
| ag_off | input | 32 | Offset |
| ag_done | output | 1 | Address result valid (one-cycle pulse) |
| ag_lin | output | 32 | Linear address, zero unless status OK |
| ag_stat | output | 2 | 0 OK, 1 LIMIT, 2 NULL, 3 BUSY |
| ag_attr | output | 4 | Attribute of the used slot, zero unless OK |

## Verification
A descriptor answer and an address request can land on the same clock edge. That edge also decides whether the request sees the loading slot as busy. The bench drives `tbl_rsp_valid` together with an address request to the loading slot and expects BUSY, then repeats the request one cycle later and expects the refilled base. A load accept is also paired with an address request to the same slot on one edge, and that request is judged against the old descriptor. During every wait the randomised traffic sends requests to the other slots, and their results must match the bench's model of those slots.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int ATTR_W = 4;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_LIMIT = 2'd1,
    ST_NULL  = 2'd2,
    ST_BUSY  = 2'd3
  } ag_stat_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
    logic              usable;
  } seg_desc_t;

  function automatic logic [ADDR_W-1:0] f_linear(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic f_beyond(input logic [ADDR_W-1:0] off,
                                    input logic [ADDR_W-1:0] lim);
    return off > lim;
  endfunction

  function automatic logic f_null_sel(input logic local_tbl, input logic [15:0] idx);
    return !local_tbl && (idx == 16'd0);
  endfunction
endpackage

// File: rtl/seg_load_ctl.sv
module seg_load_ctl
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int SEGW  = 3,
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [SEGW-1:0]  ld_seg,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_local,
  input  logic             rsp_valid,
  input  logic             rsp_present,
  output logic             pend_q,
  output logic [SEGW-1:0]  pend_seg_q,
  output logic             req_local_q,
  output logic [IDX_W-1:0] req_idx_q,
  output logic             ld_done_q,
  output logic             ld_np_q,
  output logic             wr_fill,
  output logic             wr_null,
  output logic             load_np,
  output logic [SEGW-1:0]  wr_seg
);
  localparam logic [SEGW-1:0] LAST_SEG = SEGW'(NSEG - 1);

  logic accept, is_null, start, finish;

  assign accept  = ld_valid && !pend_q && (ld_seg <= LAST_SEG);
  assign is_null = accept && f_null_sel(ld_local, 16'(ld_idx));
  assign start   = accept && !is_null;
  assign finish  = pend_q && rsp_valid;
  assign wr_fill = finish && rsp_present;
  assign load_np = finish && !rsp_present;
  assign wr_null = is_null;
  assign wr_seg  = is_null ? ld_seg : pend_seg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_seg_q  <= '0;
      req_local_q <= 1'b0;
      req_idx_q   <= '0;
      ld_done_q   <= 1'b0;
      ld_np_q     <= 1'b0;
    end else begin
      if (start) begin
        pend_q      <= 1'b1;
        pend_seg_q  <= ld_seg;
        req_local_q <= ld_local;
        req_idx_q   <= ld_idx;
      end else if (finish) begin
        pend_q <= 1'b0;
      end
      ld_done_q <= is_null || finish;
      ld_np_q   <= load_np;
    end
  end

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !rsp_valid |=> pend_q && $stable(req_idx_q) && $stable(req_local_q));
  p_null_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_null |=> !pend_q && ld_done_q);
  p_finish_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> ld_done_q && !pend_q);
  p_np_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_np_q |-> ld_done_q);
endmodule

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SEGW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fill,
  input  logic              wr_null,
  input  logic              load_np,
  input  logic [SEGW-1:0]   wr_seg,
  input  logic [ADDR_W-1:0] fill_base,
  input  logic [ADDR_W-1:0] fill_limit,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [SEGW-1:0]   rd_seg,
  output seg_desc_t         rd_desc
);
  seg_desc_t slot_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (wr_fill && wr_seg == SEGW'(i)) begin
        slot_q[i] <= '{base: fill_base, limit: fill_limit, attr: fill_attr, usable: 1'b1};
      end else if (wr_null && wr_seg == SEGW'(i)) begin
        slot_q[i] <= '0;
      end
    end

    p_keep_on_np_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_np && wr_seg == SEGW'(i) |=> $stable(slot_q[i]));
  end

  always_comb begin
    rd_desc = '0;
    for (int k = 0; k < NSEG; k++) begin
      if (rd_seg == SEGW'(k)) rd_desc = slot_q[k];
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlate_pkg::*;
#(
  parameter int SEGW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ag_valid,
  input  logic [SEGW-1:0]   ag_seg,
  input  logic [ADDR_W-1:0] ag_off,
  input  seg_desc_t         desc,
  input  logic              pend,
  input  logic [SEGW-1:0]   pend_seg,
  output logic              done_q,
  output logic [ADDR_W-1:0] lin_q,
  output ag_stat_e          stat_q,
  output logic [ATTR_W-1:0] attr_q
);
  ag_stat_e stat_d;
  logic     hit_busy, hit_over;

  assign hit_busy = pend && (pend_seg == ag_seg);
  assign hit_over = f_beyond(ag_off, desc.limit);

  always_comb begin
    if (hit_busy)         stat_d = ST_BUSY;
    else if (!desc.usable) stat_d = ST_NULL;
    else if (hit_over)    stat_d = ST_LIMIT;
    else                  stat_d = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      lin_q  <= '0;
      stat_q <= ST_OK;
      attr_q <= '0;
    end else begin
      done_q <= ag_valid;
      stat_q <= stat_d;
      lin_q  <= (stat_d == ST_OK) ? f_linear(desc.base, ag_off) : '0;
      attr_q <= (stat_d == ST_OK) ? desc.attr : '0;
    end
  end

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ag_valid |=> done_q);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ag_valid |=> !done_q);
  p_busy_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ag_valid && !pend |=> stat_q != ST_BUSY);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int IDX_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [2:0]  ld_seg,
  input  logic [15:0] ld_sel,
  output logic        ld_done,
  output logic        ld_np_fault,
  output logic        tbl_req,
  output logic        tbl_req_local,
  output logic [12:0] tbl_req_index,
  input  logic        tbl_rsp_valid,
  input  logic [31:0] tbl_rsp_base,
  input  logic [31:0] tbl_rsp_limit,
  input  logic [3:0]  tbl_rsp_attr,
  input  logic        tbl_rsp_present,
  input  logic        ag_valid,
  input  logic [2:0]  ag_seg,
  input  logic [31:0] ag_off,
  output logic        ag_done,
  output logic [31:0] ag_lin,
  output logic [1:0]  ag_stat,
  output logic [3:0]  ag_attr
);
  localparam int SEGW  = 3;
  localparam int SEL_W = IDX_W + 3;

  logic [SEGW-1:0] pend_seg, wr_seg;
  logic            pend, wr_fill, wr_null, load_np;
  logic [1:0]      sel_rpl_unused;
  seg_desc_t       rd_desc;
  ag_stat_e        stat;

  assign sel_rpl_unused = ld_sel[1:0];

  seg_load_ctl #(.NSEG(NSEG), .SEGW(SEGW), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_seg(ld_seg),
    .ld_idx(ld_sel[SEL_W-1:3]), .ld_local(ld_sel[2]),
    .rsp_valid(tbl_rsp_valid), .rsp_present(tbl_rsp_present),
    .pend_q(pend), .pend_seg_q(pend_seg),
    .req_local_q(tbl_req_local), .req_idx_q(tbl_req_index),
    .ld_done_q(ld_done), .ld_np_q(ld_np_fault),
    .wr_fill(wr_fill), .wr_null(wr_null), .load_np(load_np), .wr_seg(wr_seg)
  );

  seg_desc_bank #(.NSEG(NSEG), .SEGW(SEGW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_fill(wr_fill), .wr_null(wr_null), .load_np(load_np), .wr_seg(wr_seg),
    .fill_base(tbl_rsp_base), .fill_limit(tbl_rsp_limit), .fill_attr(tbl_rsp_attr),
    .rd_seg(ag_seg), .rd_desc(rd_desc)
  );

  seg_addr_gen #(.SEGW(SEGW)) u_ag (
    .clk(clk), .rst_n(rst_n),
    .ag_valid(ag_valid), .ag_seg(ag_seg), .ag_off(ag_off),
    .desc(rd_desc), .pend(pend), .pend_seg(pend_seg),
    .done_q(ag_done), .lin_q(ag_lin), .stat_q(stat), .attr_q(ag_attr)
  );

  assign tbl_req = pend;
  assign ag_stat = stat;

  p_idle_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && tbl_rsp_valid |=> !tbl_req);
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        ld_done, ld_np_fault, tbl_req, tbl_req_local;
  logic [12:0] tbl_req_index;
  logic        tbl_rsp_valid = 1'b0;
  logic [31:0] tbl_rsp_base = '0;
  logic [31:0] tbl_rsp_limit = '0;
  logic [3:0]  tbl_rsp_attr = '0;
  logic        tbl_rsp_present = 1'b0;
  logic        ag_valid = 1'b0;
  logic [2:0]  ag_seg = '0;
  logic [31:0] ag_off = '0;
  logic        ag_done;
  logic [31:0] ag_lin;
  logic [1:0]  ag_stat;
  logic [3:0]  ag_attr;

  always #4 clk = ~clk;

  seg_xlate dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic [3:0]  m_attr [6];
  bit          m_use  [6];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_stat(input logic [2:0] s, input logic [31:0] off, input bit busy);
    if (busy) return 2'd3;
    if (s > 3'd5) return 2'd2;
    if (!m_use[s]) return 2'd2;
    if (off > m_lim[s]) return 2'd1;
    return 2'd0;
  endfunction

  // Called just after a falling edge; returns just after the next one.
  task automatic ag_check(input logic [2:0] s, input logic [31:0] off, input bit busy, input string tag);
    logic [1:0] es;
    logic [31:0] el;
    logic [3:0] ea;
    ag_valid = 1'b1; ag_seg = s; ag_off = off;
    @(negedge clk);
    ag_valid = 1'b0;
    es = exp_stat(s, off, busy);
    el = (es == 2'd0) ? m_base[s] + off : 32'd0;
    ea = (es == 2'd0) ? m_attr[s] : 4'd0;
    chk(ag_done === 1'b1, {tag, " R2 done"}, 32'(ag_done), 32'd1);
    chk(ag_stat === es, {tag, " R3/R11 status"}, 32'(ag_stat), 32'(es));
    chk(ag_lin === el, {tag, " R2 linear"}, ag_lin, el);
    chk(ag_attr === ea, {tag, " R7 attr"}, 32'(ag_attr), 32'(ea));
  endtask

  task automatic do_load(input logic [2:0] s, input logic [15:0] sel, input bit pres,
                         input logic [31:0] b, input logic [31:0] l, input logic [3:0] a,
                         input int dly, input bit probe);
    ld_valid = 1'b1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 1'b0;
    if (sel[15:3] == 13'd0 && !sel[2]) begin
      chk(ld_done === 1'b1 && ld_np_fault === 1'b0, "R5 null load done", 32'({ld_done, ld_np_fault}), 32'd2);
      chk(tbl_req === 1'b0, "R5 null no request", 32'(tbl_req), 32'd0);
      m_use[s] = 1'b0;
      return;
    end
    chk(tbl_req === 1'b1, "R6 request raised", 32'(tbl_req), 32'd1);
    chk(tbl_req_local === sel[2] && tbl_req_index === sel[15:3], "R4 request fields",
        32'({tbl_req_local, tbl_req_index}), 32'({sel[2], sel[15:3]}));
    for (int k = 0; k < dly; k++) begin
      logic [2:0] os;
      os = 3'($urandom % 6);
      ag_check(os, $urandom, os == s, "R9 during wait");
      chk(tbl_req === 1'b1 && tbl_req_index === sel[15:3], "R6 request held",
          32'({tbl_req, tbl_req_index}), 32'({1'b1, sel[15:3]}));
    end
    tbl_rsp_valid = 1'b1; tbl_rsp_base = b; tbl_rsp_limit = l;
    tbl_rsp_attr = a; tbl_rsp_present = pres;
    if (probe) begin ag_valid = 1'b1; ag_seg = s; ag_off = 32'd0; end
    @(negedge clk);
    tbl_rsp_valid = 1'b0; ag_valid = 1'b0;
    chk(ld_done === 1'b1, "R7 load done", 32'(ld_done), 32'd1);
    chk(ld_np_fault === !pres, "R8 not-present flag", 32'(ld_np_fault), 32'(!pres));
    chk(tbl_req === 1'b0, "R6 request dropped", 32'(tbl_req), 32'd0);
    if (probe) chk(ag_stat === 2'd3, "R9 busy on response edge", 32'(ag_stat), 32'd3);
    if (pres) begin
      m_base[s] = b; m_lim[s] = l; m_attr[s] = a; m_use[s] = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) begin m_base[i] = 0; m_lim[i] = 0; m_attr[i] = 0; m_use[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(tbl_req === 1'b0 && ag_done === 1'b0 && ld_done === 1'b0, "R1 reset outputs",
        32'({tbl_req, ag_done, ld_done}), 32'd0);
    for (int i = 0; i < 8; i++) ag_check(3'(i), 32'h10, 1'b0, "R1 reset null");

    // R7 / R3 directed: limit boundary
    do_load(3'd2, 16'h0048, 1'b1, 32'h1000_0000, 32'h0000_00FF, 4'h3, 2, 1'b1);
    ag_check(3'd2, 32'h0000_00FF, 1'b0, "R3 offset at limit");
    ag_check(3'd2, 32'h0000_0100, 1'b0, "R3 offset past limit");
    ag_check(3'd2, 32'hF000_0000, 1'b0, "R3 big offset");
    // R2 wrap-around
    do_load(3'd0, 16'h0015, 1'b1, 32'hFFFF_FF00, 32'hFFFF_FFFF, 4'hA, 0, 1'b0);
    ag_check(3'd0, 32'h0000_0200, 1'b0, "R2 wrap");
    // R8 not present keeps old
    do_load(3'd2, 16'h00A0, 1'b0, 32'h5555_5555, 32'h1, 4'h1, 1, 1'b0);
    ag_check(3'd2, 32'h10, 1'b0, "R8 old kept");
    // R5 local index 0 is a real request; global 0 is null
    do_load(3'd4, 16'h0006, 1'b1, 32'h0000_4000, 32'h0FFF, 4'h5, 1, 1'b0);
    ag_check(3'd4, 32'h0123, 1'b0, "R5 local zero usable");
    do_load(3'd4, 16'h0003, 1'b1, 0, 0, 0, 0, 1'b0);
    ag_check(3'd4, 32'h0, 1'b0, "R5 null on use");

    // R12: load accepted on same edge as address request to that slot
    ld_valid = 1'b1; ld_seg = 3'd2; ld_sel = 16'h0100;
    ag_valid = 1'b1; ag_seg = 3'd2; ag_off = 32'h20;
    @(negedge clk);
    ld_valid = 1'b0; ag_valid = 1'b0;
    chk(ag_stat === 2'd0 && ag_lin === m_base[2] + 32'h20, "R12 old descriptor on accept edge",
        ag_lin, m_base[2] + 32'h20);
    // R10: second load while waiting is ignored
    ld_valid = 1'b1; ld_seg = 3'd3; ld_sel = 16'h0208;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(tbl_req_index === 13'h020, "R10 index unchanged", 32'(tbl_req_index), 32'h20);
    tbl_rsp_valid = 1'b1; tbl_rsp_base = 32'h0002_0000; tbl_rsp_limit = 32'hFFFF;
    tbl_rsp_attr = 4'h7; tbl_rsp_present = 1'b1;
    @(negedge clk);
    tbl_rsp_valid = 1'b0;
    m_base[2] = 32'h0002_0000; m_lim[2] = 32'hFFFF; m_attr[2] = 4'h7; m_use[2] = 1'b1;
    chk(ld_done === 1'b1, "R7 done after pair", 32'(ld_done), 32'd1);
    ag_check(3'd3, 32'h4, 1'b0, "R10 ignored load left slot null");
    ag_check(3'd2, 32'h8, 1'b0, "R7 refilled slot");
    // R10: response while idle, and load to slot code 6
    tbl_rsp_valid = 1'b1; tbl_rsp_base = 32'hDEAD_0000; tbl_rsp_present = 1'b1;
    ld_valid = 1'b0;
    @(negedge clk);
    tbl_rsp_valid = 1'b0;
    chk(ld_done === 1'b0, "R10 idle response no done", 32'(ld_done), 32'd0);
    ld_valid = 1'b1; ld_seg = 3'd6; ld_sel = 16'h0040;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(tbl_req === 1'b0 && ld_done === 1'b0, "R10 slot 6 ignored", 32'({tbl_req, ld_done}), 32'd0);
    ag_check(3'd2, 32'h8, 1'b0, "R10 slot intact");

    // Constrained random traffic
    for (int it = 0; it < 400; it++) begin
      logic [2:0] s;
      s = 3'($urandom % 6);
      if ($urandom % 10 < 4) begin
        logic [15:0] sel;
        logic [31:0] lim;
        sel = $urandom;
        if ($urandom % 8 == 0) sel = {14'd0, sel[1:0]};
        lim = ($urandom % 2) ? ($urandom % 4096) : ($urandom % 32'hFFFF_FFF0);
        do_load(s, sel, ($urandom % 5) != 0, $urandom, lim, 4'($urandom), $urandom % 4, $urandom % 2);
      end else begin
        logic [31:0] off;
        case ($urandom % 4)
          0: off = m_lim[s];
          1: off = m_lim[s] + 32'd1;
          2: off = m_lim[s] - 32'd1;
          default: off = $urandom;
        endcase
        ag_check(s, off, 1'b0, "R3 random");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule